// File: doc/BRIEF.md
# Split-Word User Counter

This block is a 63-bit up-counter meant to serve as a fine-grained timestamp or a user-managed elapsed-time counter. The count is kept in steps of 512: the nine least significant bits are always zero, and each accepted tick adds one unit of bit 9. A tick-enable input, typically pulsed every 500 ns, paces the counter. Software can start it, stop it and preload it.

Software reaches the counter through a word-addressed register port with 32-bit data. The count is split into a high word and a low word, and each word is read and written on its own. A sticky flag records that the count has run past its largest value. That flag shares the top bit of the high word. The block never raises an interrupt.

There is no snapshot latch, so a read of either word returns the live count in the cycle of the read. Software that needs a consistent 63-bit value has to handle a carry between the two reads itself.

Top module: `suc_user_counter`

## Requirements
- R1: After reset, the count is zero, the wrap flag is clear and the run bit is 1.
- R2: While the run bit is 1, each cycle with `tick_i` high adds 0x200 to the 63-bit count. While the run bit is 0, ticks change nothing.
- R3: A read of offset 0 returns the wrap flag in bit 31 and count bits 62..32 in bits 30..0.
- R4: A read of offset 1 returns count bits 31..0, and bits 8..0 of this value always read as zero.
- R5: A write to offset 0 loads count bits 62..32 from `wdata[30:0]`, discards `wdata[31]`, keeps the low word and clears the wrap flag.
- R6: A write to offset 1 loads count bits 31..9 from `wdata[31:9]`, ignores `wdata[8:0]`, keeps the high word and clears the wrap flag.
- R7: A write to offset 3 stores `wdata[0]` as the run bit (1 runs, 0 stops). A read of offset 3 returns the run bit in bit 0 and zeros elsewhere. A tick in the same cycle as this write is governed by the old run bit.
- R8: A tick at the largest count, 0x7FFF_FFFF_FFFF_FE00, wraps the count to zero and sets the wrap flag. The flag then stays set through later ticks until a write to offset 0 or offset 1.
- R9: A write to offset 2 changes neither the count, the flag nor the run bit. A read of offset 2 returns zero.
- R10: When a write to offset 0 or offset 1 falls in the same cycle as a tick, the loaded value is kept and that tick is dropped.
- R11: `irq_o` stays low at all times.
- R12: Read data appears on `rdata` with `rd_valid` high exactly one cycle after `rd_en`. Each read samples the live count of its own cycle, so a carry between the two words shows up between separate reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable, one pulse per counting period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word offset: 0 high word, 1 low word, 2 unused, 3 run control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rdata` holds a read result |
| irq_o | output | 1 | Interrupt line, always low |

## Verification
The counter is driven in four ways, and each one separates behaviours that could otherwise be confused:

- **Short runs of ticks from zero** show that the step lands on bit 9 rather than bit 0.
- **Ticks with the run bit cleared** separate a gated counter from a free-running one.
- **A preload of all ones in the low word followed by one tick** shows the carry into the high word. Reading the words in separate cycles around that tick confirms there is no snapshot.
- **A preload of the largest value followed by several ticks** separates a wrap with a sticky flag from a saturating counter or a self-clearing flag.

Collisions between writes and ticks, including a run-bit write on a tick cycle, decide which of the two takes precedence.

// File: rtl/suc_pkg.sv
package suc_pkg;

  // Word offsets; their meaning is fixed by the register map behaviour.
  typedef enum logic [1:0] {
    OFS_HIGH  = 2'd0,
    OFS_LOW   = 2'd1,
    OFS_SPARE = 2'd2,
    OFS_RUN   = 2'd3
  } suc_ofs_e;

  // Decoded write strobes handed from the decoder to the counter core.
  typedef struct packed {
    logic ld_high;
    logic ld_low;
    logic ld_run;
  } suc_wr_s;

endpackage

// File: rtl/suc_wr_decode.sv
module suc_wr_decode
  import suc_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] addr,
  output suc_wr_s    wr_o
);

  always_comb begin
    wr_o = '0;
    if (wr_en) begin
      unique case (suc_ofs_e'(addr))
        OFS_HIGH:  wr_o.ld_high = 1'b1;
        OFS_LOW:   wr_o.ld_low  = 1'b1;
        OFS_RUN:   wr_o.ld_run  = 1'b1;
        default:   wr_o         = '0;
      endcase
    end
  end

endmodule

// File: rtl/suc_count_core.sv
module suc_count_core
  import suc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 63,
  parameter int unsigned STEP_BIT = 9,
  parameter bit          RUN_RST  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  suc_wr_s                   wr_i,
  input  logic [DATA_W-1:0]         wdata,
  output logic [CNT_W-STEP_BIT-1:0] units_o,
  output logic                      wrap_o,
  output logic                      run_o
);

  localparam int unsigned UNIT_W = CNT_W - STEP_BIT;
  localparam int unsigned HI_W   = CNT_W - DATA_W;
  localparam int unsigned LO_U_W = DATA_W - STEP_BIT;
  localparam logic [UNIT_W-1:0] UNIT_ONE = UNIT_W'(1);

  logic [UNIT_W-1:0] units_q;
  logic              wrap_q;
  logic              run_q;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[STEP_BIT-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      units_q <= '0;
      wrap_q  <= 1'b0;
      run_q   <= RUN_RST;
    end else begin
      if (wr_i.ld_high) begin
        units_q[UNIT_W-1:LO_U_W] <= wdata[HI_W-1:0];
        wrap_q                   <= 1'b0;
      end else if (wr_i.ld_low) begin
        units_q[LO_U_W-1:0] <= wdata[DATA_W-1:STEP_BIT];
        wrap_q              <= 1'b0;
      end else if (tick_i && run_q) begin
        if (&units_q) begin
          units_q <= '0;
          wrap_q  <= 1'b1;
        end else begin
          units_q <= units_q + UNIT_ONE;
        end
      end
      if (wr_i.ld_run) begin
        run_q <= wdata[0];
      end
    end
  end

  assign units_o = units_q;
  assign wrap_o  = wrap_q;
  assign run_o   = run_q;

endmodule

// File: rtl/suc_read_port.sv
module suc_read_port
  import suc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 63,
  parameter int unsigned STEP_BIT = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [1:0]                addr,
  input  logic [CNT_W-STEP_BIT-1:0] units_i,
  input  logic                      wrap_i,
  input  logic                      run_i,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rd_valid
);

  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  assign count = {units_i, {STEP_BIT{1'b0}}};

  always_comb begin
    unique case (suc_ofs_e'(addr))
      OFS_HIGH: rd_mux = {wrap_i, count[CNT_W-1:DATA_W]};
      OFS_LOW:  rd_mux = count[DATA_W-1:0];
      OFS_RUN:  rd_mux = {{(DATA_W-1){1'b0}}, run_i};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/suc_user_counter.sv
module suc_user_counter
  import suc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STEP_BIT = 9,
  parameter bit          RUN_RST  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              irq_o
);

  // The count fills two words less the word bit taken by the wrap flag.
  localparam int unsigned CNT_W  = 2 * DATA_W - 1;
  localparam int unsigned UNIT_W = CNT_W - STEP_BIT;

  suc_wr_s           wr_s;
  logic [UNIT_W-1:0] units;
  logic              wrap;
  logic              run;

  suc_wr_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wr_o  (wr_s)
  );

  suc_count_core #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .STEP_BIT (STEP_BIT),
    .RUN_RST  (RUN_RST)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .wr_i    (wr_s),
    .wdata   (wdata),
    .units_o (units),
    .wrap_o  (wrap),
    .run_o   (run)
  );

  suc_read_port #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .STEP_BIT (STEP_BIT)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .units_i  (units),
    .wrap_i   (wrap),
    .run_i    (run),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  // R11: this counter has no interrupt source.
  assign irq_o = 1'b0;

endmodule

// File: rtl/suc_checker.sv
module suc_checker #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STEP_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid
);

  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_no_stray_valid_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_low_zero_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd1) |=> (rdata[STEP_BIT-1:0] == '0));

  assert_run_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |=> (rdata[DATA_W-1:1] == '0));

  assert_spare_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd2) |=> (rdata == '0));

  assert_high_clears_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) ##1 (rd_en && addr == 2'd0) |=> !rdata[DATA_W-1]);

endmodule

bind suc_user_counter suc_checker #(
  .DATA_W   (DATA_W),
  .STEP_BIT (STEP_BIT)
) u_suc_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .rd_valid (rd_valid)
);

// File: tb/tb_suc_user_counter.sv
`timescale 1ns/1ps
module tb_suc_user_counter;

  localparam logic [63:0] STEP = 64'h200;
  localparam logic [63:0] CMAX = 64'h7FFF_FFFF_FFFF_FE00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit irq_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // Bench model of the counter state.
  logic [63:0] m_cnt = '0;
  logic        m_wrap = 1'b0;
  logic        m_run = 1'b1;

  always #5 clk = ~clk;

  suc_user_counter dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_wrap, m_cnt[62:32]};
      2'd1:    return m_cnt[31:0];
      2'd3:    return {31'd0, m_run};
      default: return 32'd0;
    endcase
  endfunction

  // Driver: one clock cycle of stimulus, with expectations queued for reads.
  task automatic cyc(input logic t, input logic w, input logic r,
                     input logic [1:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    tick_i = t; wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    if (w && a == 2'd0) begin
      m_cnt  = {1'b0, d[30:0], m_cnt[31:0]};
      m_wrap = 1'b0;
    end else if (w && a == 2'd1) begin
      m_cnt  = {m_cnt[63:32], d[31:9], 9'd0};
      m_wrap = 1'b0;
    end else if (t && m_run) begin
      if (m_cnt == CMAX) begin
        m_cnt  = '0;
        m_wrap = 1'b1;
      end else begin
        m_cnt = m_cnt + STEP;
      end
    end
    if (w && a == 2'd3) m_run = d[0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'd0, "");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b0, 1'b0, 1'b1, a, 32'd0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, 1'b0, a, d, "");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'd0, "");
  endtask

  // Monitor: compare each returned word against the oldest expectation.
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_o) irq_seen = 1'b1;
      if (rd_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R12: unexpected read data %h, expected none", rdata);
        end else begin
          logic [31:0] e;
          string       tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s: read %h expected %h", tg, rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(2'd0, "R1 high after reset");
    rd(2'd1, "R1 low after reset");
    rd(2'd3, "R1 run after reset");

    // R2 counting steps at bit 9
    ticks(5);
    rd(2'd1, "R2 five ticks");
    // R7 stop, ticks ignored
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, "R7 run reads 0 after stop");
    ticks(4);
    rd(2'd1, "R2 ticks ignored while stopped");
    // R7 start with tick on the same cycle: old run bit (0) governs
    cyc(1'b1, 1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, "");
    rd(2'd1, "R7 tick on run write uses old run");
    rd(2'd3, "R7 run reads 1 after start");

    // R6 low write ignores bits 8..0; R12 carry between separate reads
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, "R6 low load masks bits 8..0");
    cyc(1'b1, 1'b0, 1'b1, 2'd1, 32'd0, "R12 low read before carry");
    rd(2'd0, "R12 high read shows carry");
    rd(2'd1, "R4 low after carry");

    // R5 high write drops bit 31, keeps low half
    wr(2'd1, 32'h1234_5600);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, "R5 high load masked to 31 bits");
    rd(2'd1, "R5 low kept after high load");

    // R9 offset 2 write has no effect
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd0, "R9 high after spare write");
    rd(2'd1, "R9 low after spare write");
    rd(2'd2, "R9 spare reads zero");

    // R8 wrap at max sets sticky flag
    wr(2'd1, 32'hFFFF_FE00);
    wr(2'd0, 32'h7FFF_FFFF);
    rd(2'd0, "R3 high at max");
    ticks(1);
    rd(2'd0, "R8 wrap flag set, count zero");
    rd(2'd1, "R8 low zero after wrap");
    ticks(3);
    rd(2'd0, "R8 flag sticky over ticks");
    rd(2'd1, "R8 count resumes after wrap");
    wr(2'd1, 32'h0000_0400);
    rd(2'd0, "R6 low write clears flag");

    // R10 write on tick cycle wins
    cyc(1'b1, 1'b1, 1'b0, 2'd1, 32'h0000_1000, "");
    rd(2'd1, "R10 low load beats tick");
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 32'h0000_0055, "");
    rd(2'd0, "R10 high load beats tick");
    rd(2'd1, "R10 low kept on high load");

    // R5 flag cleared by high write
    wr(2'd1, 32'hFFFF_FE00);
    wr(2'd0, 32'h7FFF_FFFF);
    ticks(1);
    rd(2'd0, "R8 flag set again");
    wr(2'd0, 32'h0000_0003);
    rd(2'd0, "R5 high write clears flag");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
    end
    checks++;
    if (irq_seen) begin
      errors++;
      $display("FAIL R11: irq_o seen 1, expected 0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule